// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

This block serves one bank of general-purpose pins. Each pin can be an output, which drives a value held in a data register, or an input, whose level is synchronised into the clock domain. Software reaches the bank through a plain word-addressed register port. It uses a write strobe that takes effect on the clock edge, and a read strobe whose data is registered one cycle later.

Every input pin can raise an interrupt. Three per-pin mask registers choose the trigger type for each pin: falling edge, rising edge, both edges, low level or high level. When the selected condition occurs on an enabled pin, the pin's status bit is set. The bit stays set until software clears it by writing a one to it. A single interrupt output is the OR of all status bits.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `pin_oe`, `pin_out` and `irq` are 0. Word addresses: 0 data, 1 direction, 2 enable, 3 type0, 4 type1, 5 type2, 6 status. A read returns the addressed word on `rd_data` one clock after the `rd_en` edge.
- R2: A direction bit of 1 makes the pin an output (`pin_oe` bit = 1) and 0 makes it an input. `pin_out` carries the data register, and both follow a write on the next edge.
- R3: Reading word 0 returns the data register bit for output pins. For input pins it returns the pin level after a two-flop synchroniser.
- R4: With type1=0, type2=0 and type0=0, a high-to-low transition of the synchronised pin sets its status bit.
- R5: With type1=0, type2=0 and type0=1, a low-to-high transition sets its status bit.
- R6: With type1=0 and type2=1, either transition sets the status bit, whatever type0 holds.
- R7: With type1=1 and type0=0, status is set on every cycle the pin is low, so a clear is undone at once while the level persists.
- R8: With type1=1 and type0=1, status is set on every cycle the pin is high. type1=1 overrides type2.
- R9: A pin whose enable bit is 0 never sets its status bit.
- R10: Writing word 6 clears each status bit written as 1 and leaves bits written as 0 unchanged. Status bit n belongs to pin n.
- R11: When a clear and a new event hit the same bit in the same cycle, the bit remains set.
- R12: `irq` is 1 exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Word address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Levels driven on output pins |
| pin_oe | output | 32 | Output enables, 1 = drive |
| irq | output | 1 | OR of all status bits |

## Verification
The properties assume `wr_data` and `reg_addr` are known whenever `wr_en` is high. They also assume that every status bit drops only because of a write to word 6. The stimulus keeps to this: it drives all port inputs to defined values from time zero and moves them only on falling clock edges. Pin changes go in while the enable word is 0, or while the pin's status is being observed, and each change is held long enough to pass the synchroniser and the edge detector. The one case that needs exact alignment is a clear landing on the same edge as an event. For it, the clear is issued two edges after the pin changes, which is when the detector fires.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_EN   = 3'd2,
        SEL_T0   = 3'd3,
        SEL_T1   = 3'd4,
        SEL_T2   = 3'd5,
        SEL_STAT = 3'd6,
        SEL_NONE = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] en,
    input  logic [W-1:0] t0,
    input  logic [W-1:0] t1,
    input  logic [W-1:0] t2,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_d, prev_q;

    assign prev_d = level;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar p = 0; p < W; p++) begin : g_pin
        logic rise, fall, cond;
        always_comb begin
            rise = level[p] & ~prev_q[p];
            fall = ~level[p] & prev_q[p];
            if (t1[p])      cond = t0[p] ? level[p] : ~level[p];
            else if (t2[p]) cond = rise | fall;
            else if (t0[p]) cond = rise;
            else            cond = fall;
            hit[p] = en[p] & cond;
        end
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_data,
    input  logic              rd_en,
    output logic [W-1:0]      rd_data,
    input  logic [W-1:0]      level,
    input  logic [W-1:0]      hit,
    output logic [W-1:0]      data_o,
    output logic [W-1:0]      dir_o,
    output logic [W-1:0]      en_o,
    output logic [W-1:0]      t0_o,
    output logic [W-1:0]      t1_o,
    output logic [W-1:0]      t2_o,
    output logic [W-1:0]      stat_o
);
    typedef struct packed {
        logic [W-1:0] data;
        logic [W-1:0] dir;
        logic [W-1:0] en;
        logic [W-1:0] t0;
        logic [W-1:0] t1;
        logic [W-1:0] t2;
        logic [W-1:0] stat;
        logic [W-1:0] rdata;
    } regs_t;

    regs_t    r_d, r_q;
    reg_sel_e sel;
    logic [W-1:0] clr, rmux;

    always_comb begin
        sel = reg_sel_e'(reg_addr);
        r_d = r_q;
        clr = '0;
        if (wr_en) begin
            case (sel)
                SEL_DATA: r_d.data = wr_data;
                SEL_DIR:  r_d.dir  = wr_data;
                SEL_EN:   r_d.en   = wr_data;
                SEL_T0:   r_d.t0   = wr_data;
                SEL_T1:   r_d.t1   = wr_data;
                SEL_T2:   r_d.t2   = wr_data;
                SEL_STAT: clr      = wr_data;
                default:  ;
            endcase
        end
        // a new event takes priority over a clear on the same bit
        r_d.stat = (r_q.stat & ~clr) | hit;
        case (sel)
            SEL_DATA: rmux = (r_q.data & r_q.dir) | (level & ~r_q.dir);
            SEL_DIR:  rmux = r_q.dir;
            SEL_EN:   rmux = r_q.en;
            SEL_T0:   rmux = r_q.t0;
            SEL_T1:   rmux = r_q.t1;
            SEL_T2:   rmux = r_q.t2;
            SEL_STAT: rmux = r_q.stat;
            default:  rmux = '0;
        endcase
        if (rd_en) r_d.rdata = rmux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data = r_q.rdata;
    assign data_o  = r_q.data;
    assign dir_o   = r_q.dir;
    assign en_o    = r_q.en;
    assign t0_o    = r_q.t0;
    assign t1_o    = r_q.t1;
    assign t2_o    = r_q.t2;
    assign stat_o  = r_q.stat;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [NPINS-1:0]  wr_data,
    input  logic              rd_en,
    output logic [NPINS-1:0]  rd_data,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] level_w, hit_w, data_w, dir_w, en_w;
    logic [NPINS-1:0] t0_w, t1_w, t2_w, stat_w;

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(level_w)
    );

    gpio_trigger #(.W(NPINS)) u_trig (
        .clk(clk), .rst_n(rst_n), .level(level_w), .en(en_w),
        .t0(t0_w), .t1(t1_w), .t2(t2_w), .hit(hit_w)
    );

    gpio_regs #(.W(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .level(level_w), .hit(hit_w), .data_o(data_w), .dir_o(dir_w),
        .en_o(en_w), .t0_o(t0_w), .t1_o(t1_w), .t2_o(t2_w), .stat_o(stat_w)
    );

    assign pin_out = data_w;
    assign pin_oe  = dir_w;
    assign irq     = |stat_w;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wr_en,
    input logic [W-1:0]      wr_data,
    input logic [W-1:0]      pin_oe,
    input logic              irq,
    input logic [W-1:0]      stat_w,
    input logic [W-1:0]      en_w
);
    logic [W-1:0] clr_mask;
    assign clr_mask = (wr_en && reg_addr == SEL_STAT) ? wr_data : '0;

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == SEL_DIR) |=> (pin_oe == $past(wr_data))); // R2

    AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_w & ~$past(stat_w) & ~$past(en_w)) == '0)); // R9

    AST_NO_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_w) & ~stat_w & ~$past(clr_mask)) == '0)); // R10

    AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq == (stat_w != '0))); // R12
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.W(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .pin_oe(pin_oe), .irq(irq), .stat_w(stat_w),
    .en_w(en_w)
);

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
    localparam logic [31:0] P_START = 32'h0000_FFFF;
    localparam logic [31:0] P_END   = 32'h00FF_00FF;
    // {type0, type1, type2, expected status}
    localparam logic [34:0] VEC [7] = '{
        {3'b000, 32'h0000_FF00},   // R4 falling
        {3'b100, 32'h00FF_0000},   // R5 rising
        {3'b101, 32'h00FF_FF00},   // R6 both, type0=1
        {3'b001, 32'h00FF_FF00},   // R6 both, type0=0
        {3'b010, 32'hFFFF_FF00},   // R7 level low
        {3'b110, 32'h00FF_FFFF},   // R8 level high
        {3'b111, 32'h00FF_FFFF}    // R8 level overrides type2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;
    int checks = 0;
    int fails  = 0;
    logic [31:0] v;

    always #10 clk = ~clk;

    gpio_irq_bank dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; rd_en = 1'b1;
        @(negedge clk);
        d = rd_data; rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk("R1 register", v, 32'h0);
        end

        // table of trigger modes
        for (int i = 0; i < 7; i++) begin
            wr(3'd2, 32'h0);
            pin_in = P_START;
            wr(3'd3, {32{VEC[i][34]}});
            wr(3'd4, {32{VEC[i][33]}});
            wr(3'd5, {32{VEC[i][32]}});
            idle(4);
            wr(3'd6, 32'hFFFF_FFFF);
            wr(3'd2, 32'hFFFF_FFFF);
            pin_in = P_END;
            idle(5);
            rd(3'd6, v);
            chk("R4-R8 mode table status", v, VEC[i][31:0]);
            chk("R12 irq set", {31'h0, irq}, 32'h1);
        end

        // R2 / R3 direction and data
        wr(3'd2, 32'h0);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd1, 32'h0000_00F0);
        wr(3'd0, 32'hA5A5_A5A5);
        chk("R2 pin_oe", pin_oe, 32'h0000_00F0);
        chk("R2 pin_out", pin_out, 32'hA5A5_A5A5);
        pin_in = 32'h1234_5678;
        idle(3);
        rd(3'd0, v);
        chk("R3 data readback", v, 32'h1234_56A8);

        // R9 enable gating, rising mode
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd4, 32'h0);
        wr(3'd5, 32'h0);
        pin_in = 32'h0;
        idle(4);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd2, 32'h0000_0001);
        pin_in = 32'hFFFF_FFFF;
        idle(5);
        rd(3'd6, v);
        chk("R9 disabled pins stay clear", v, 32'h0000_0001);

        // R10 / R12 write-one-to-clear
        pin_in = 32'h0;
        idle(4);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFFF);
        pin_in = 32'h00FF_0000;
        idle(5);
        wr(3'd6, 32'h0001_0000);
        rd(3'd6, v);
        chk("R10 clear one bit", v, 32'h00FE_0000);
        wr(3'd6, 32'h0);
        rd(3'd6, v);
        chk("R10 zero write no effect", v, 32'h00FE_0000);
        chk("R12 irq high", {31'h0, irq}, 32'h1);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, v);
        chk("R10 clear all", v, 32'h0);
        chk("R12 irq low", {31'h0, irq}, 32'h0);

        // R7 level low reasserts after clear
        wr(3'd2, 32'h0);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd3, 32'h0);
        pin_in = 32'hFFFF_FFFE;
        idle(4);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFFF);
        idle(2);
        rd(3'd6, v);
        chk("R7 level low set", v, 32'h1);
        wr(3'd6, 32'h1);
        rd(3'd6, v);
        chk("R7 reassert after clear", v, 32'h1);
        pin_in = 32'hFFFF_FFFF;
        idle(4);
        wr(3'd6, 32'h1);
        rd(3'd6, v);
        chk("R7 level removed", v, 32'h0);

        // R11 event and clear on the same edge
        wr(3'd2, 32'h0);
        wr(3'd4, 32'h0);
        wr(3'd3, 32'hFFFF_FFFF);
        pin_in = 32'h0;
        idle(4);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFFF);
        pin_in = 32'h1;
        idle(5);
        pin_in = 32'h3;
        idle(2);
        wr(3'd6, 32'h3);
        rd(3'd6, v);
        chk("R11 event beats clear", v, 32'h2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule